// File: doc/BRIEF.md
# Newton-iteration square root unit

This block takes an unsigned fixed-point operand and returns its square root. It runs a multicycle datapath under a controller state machine. The datapath holds registers for the operand, the running estimate, a temporary and a small loop counter. One combinational operation unit is shared by the add, multiply and divide steps, and the halving costs no logic because it is a fixed one-bit shift. A start pulse with the operand begins a computation. The result is valid when a one-cycle done pulse appears.

The unit first forms a straight-line seed from the operand using a fitted slope and bias. It then applies a fixed number of Newton updates, each replacing the estimate with half of the sum of the estimate and the operand divided by the estimate. There is no convergence test, so every operand takes the same statically scheduled number of cycles. That fixed latency makes the block easy to slot into a surrounding pipeline schedule.

Top module: `nsq_top`

## Requirements
- R1: During and after reset, with no start accepted, `ready` is 1, `done` is 0 and `y_out` is 0.
- R2: A start is accepted on a rising clock edge where `start` and `ready` are both 1. The operand on `x_in` is captured at that edge, and `ready` is 0 in the following cycle.
- R3: With the default parameters, `done` is 1 in exactly one cycle per accepted start. That cycle is the 23rd after the accepting edge: 3 seed steps plus 4 iterations of 5 steps, one clock per step.
- R4: Operands and results are unsigned with 15 fraction bits, so the code value equals the value times 32768. For every operand code from 2048 (1/16) to 32767, `y_out` in the done cycle is within 4 codes of round(sqrt(x_in/32768)*32768).
- R5: A `start` pulse while a computation is in progress (`ready` 0) has no effect. The result and the done cycle are those of the operand first accepted.
- R6: From the done cycle until the next accepted start, `y_out` holds the result. `ready` is 1 from the cycle after done.
- R7: At the range ends, operand 2048 gives a result within 4 codes of 8192, and operand 32767 gives a result within 4 codes of 32767.
- R8: `start` held high in the done cycle is not accepted at the edge that ends it. Held one more cycle, it is accepted and produces a full, correct computation of 23 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a computation, sampled when ready |
| x_in | input | DATA_W (16) | Operand, unsigned, FRAC_W (15) fraction bits |
| ready | output | 1 | Unit idle and able to accept a start |
| done | output | 1 | One-cycle pulse marking the final control step |
| y_out | output | DATA_W (16) | Square root estimate, same format as the operand |

## Verification
A sequencing fault in the controller shows at once as a done pulse that moves off cycle 23. A fault in the loop counter moves done by whole multiples of five cycles, because an iteration is added or lost. A wrong operand select or a dropped halving corrupts the estimate far beyond the 4-code tolerance, and this is visible at the first done pulse. Start handling faults show within a cycle, either as `ready` failing to fall after acceptance or as a second operand overwriting the one being computed.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

   typedef enum logic [1:0] {
      ALU_NOP = 2'd0,
      ALU_ADD = 2'd1,
      ALU_MUL = 2'd2,
      ALU_DIV = 2'd3
   } alu_op_e;

   typedef enum logic [2:0] {
      OPD_X  = 3'd0,
      OPD_Y  = 3'd1,
      OPD_T  = 3'd2,
      OPD_K0 = 3'd3,
      OPD_K1 = 3'd4
   } opnd_e;

   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_T    = 2'd1,
      DST_Y    = 2'd2
   } dst_e;

   typedef struct packed {
      opnd_e a_sel;
      opnd_e b_sel;
      dst_e  dst;
      logic  halve;
      logic  cnt_clr;
      logic  cnt_inc;
   } dp_ctl_t;

   typedef enum logic [3:0] {
      ST_IDLE     = 4'd0,
      ST_SEED_MUL = 4'd1,
      ST_SEED_ADD = 4'd2,
      ST_CLR      = 4'd3,
      ST_DIV      = 4'd4,
      ST_AVG      = 4'd5,
      ST_INC      = 4'd6,
      ST_TEST     = 4'd7,
      ST_END      = 4'd8
   } state_e;

endpackage

// File: rtl/nsq_ctrl.sv
module nsq_ctrl
   import nsq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            cnt_zero,
   output alu_op_e         alu_op,
   output dp_ctl_t         dpc,
   output logic            load_x,
   output logic            ready,
   output logic            done
);

   state_e state_q, state_d;
   logic   last_q;

   assign ready  = (state_q == ST_IDLE);
   assign load_x = ready && start;
   assign done   = (state_q == ST_END) && last_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:     if (start) state_d = ST_SEED_MUL;
         ST_SEED_MUL: state_d = ST_SEED_ADD;
         ST_SEED_ADD: state_d = ST_CLR;
         ST_CLR:      state_d = ST_DIV;
         ST_DIV:      state_d = ST_AVG;
         ST_AVG:      state_d = ST_INC;
         ST_INC:      state_d = ST_TEST;
         ST_TEST:     state_d = ST_END;
         ST_END:      state_d = last_q ? ST_IDLE : ST_DIV;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      alu_op      = ALU_NOP;
      dpc.a_sel   = OPD_X;
      dpc.b_sel   = OPD_X;
      dpc.dst     = DST_NONE;
      dpc.halve   = 1'b0;
      dpc.cnt_clr = 1'b0;
      dpc.cnt_inc = 1'b0;
      case (state_q)
         ST_SEED_MUL: begin
            alu_op    = ALU_MUL;
            dpc.a_sel = OPD_K1;
            dpc.b_sel = OPD_X;
            dpc.dst   = DST_T;
         end
         ST_SEED_ADD: begin
            alu_op    = ALU_ADD;
            dpc.a_sel = OPD_T;
            dpc.b_sel = OPD_K0;
            dpc.dst   = DST_Y;
         end
         ST_CLR: dpc.cnt_clr = 1'b1;
         ST_DIV: begin
            alu_op    = ALU_DIV;
            dpc.a_sel = OPD_X;
            dpc.b_sel = OPD_Y;
            dpc.dst   = DST_T;
         end
         ST_AVG: begin
            alu_op    = ALU_ADD;
            dpc.a_sel = OPD_Y;
            dpc.b_sel = OPD_T;
            dpc.dst   = DST_Y;
            dpc.halve = 1'b1;
         end
         ST_INC: dpc.cnt_inc = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         last_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_TEST) last_q <= cnt_zero;
         else if (state_q == ST_IDLE) last_q <= 1'b0;
      end
   end

endmodule

// File: rtl/nsq_alu.sv
module nsq_alu
   import nsq_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int FRAC_W    = 15,
   parameter bit MUL_ROUND = 1'b0
) (
   input  alu_op_e             op,
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   output logic [DATA_W:0]     res
);

   localparam int RES_W  = DATA_W + 1;
   localparam int PROD_W = 2 * DATA_W;
   localparam int NUM_W  = DATA_W + FRAC_W;

   logic [PROD_W-1:0] prod, prod_adj, prod_sh;
   logic [NUM_W-1:0]  num, quot;
   logic [RES_W-1:0]  add_res, mul_res, div_res;

   assign prod = PROD_W'(a) * PROD_W'(b);

   generate
      if (MUL_ROUND) begin : g_mul_round
         assign prod_adj = prod + (PROD_W'(1) << (FRAC_W - 1));
      end else begin : g_mul_trunc
         assign prod_adj = prod;
      end
   endgenerate

   assign prod_sh = prod_adj >> FRAC_W;
   assign mul_res = (|prod_sh[PROD_W-1:RES_W]) ? '1 : prod_sh[RES_W-1:0];

   assign num     = {a, {FRAC_W{1'b0}}};
   assign quot    = (b == '0) ? '1 : num / NUM_W'(b);
   assign div_res = (|quot[NUM_W-1:RES_W]) ? '1 : quot[RES_W-1:0];

   assign add_res = {1'b0, a} + {1'b0, b};

   always_comb begin
      case (op)
         ALU_ADD: res = add_res;
         ALU_MUL: res = mul_res;
         ALU_DIV: res = div_res;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/nsq_datapath.sv
module nsq_datapath
   import nsq_pkg::*;
#(
   parameter int  DATA_W     = 16,
   parameter int  FRAC_W     = 15,
   parameter int  CNT_W      = 2,
   parameter real SEED_BIAS  = 0.222222,
   parameter real SEED_SLOPE = 0.888889
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_x,
   input  logic [DATA_W-1:0] x_in,
   input  dp_ctl_t           dpc,
   input  logic [DATA_W:0]   alu_res,
   output logic [DATA_W-1:0] opa,
   output logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] y,
   output logic              cnt_zero
);

   localparam logic [DATA_W-1:0] K0 = DATA_W'($rtoi(SEED_BIAS  * (2.0 ** FRAC_W) + 0.5));
   localparam logic [DATA_W-1:0] K1 = DATA_W'($rtoi(SEED_SLOPE * (2.0 ** FRAC_W) + 0.5));

   logic [DATA_W-1:0] x_q, y_q, t_q;
   logic [CNT_W-1:0]  i_q;

   function automatic logic [DATA_W-1:0] pick(input opnd_e s,
                                              input logic [DATA_W-1:0] xv,
                                              input logic [DATA_W-1:0] yv,
                                              input logic [DATA_W-1:0] tv);
      case (s)
         OPD_X:   pick = xv;
         OPD_Y:   pick = yv;
         OPD_T:   pick = tv;
         OPD_K0:  pick = K0;
         OPD_K1:  pick = K1;
         default: pick = '0;
      endcase
   endfunction

   assign opa      = pick(dpc.a_sel, x_q, y_q, t_q);
   assign opb      = pick(dpc.b_sel, x_q, y_q, t_q);
   assign y        = y_q;
   assign cnt_zero = (i_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
         t_q <= '0;
         i_q <= '0;
      end else begin
         if (load_x) x_q <= x_in;
         case (dpc.dst)
            DST_T:   t_q <= alu_res[DATA_W-1:0];
            DST_Y:   y_q <= dpc.halve ? alu_res[DATA_W:1] : alu_res[DATA_W-1:0];
            default: ;
         endcase
         if (dpc.cnt_clr)      i_q <= '0;
         else if (dpc.cnt_inc) i_q <= i_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/nsq_top.sv
module nsq_top
   import nsq_pkg::*;
#(
   parameter int  DATA_W     = 16,
   parameter int  FRAC_W     = 15,
   parameter int  ITERS      = 4,
   parameter bit  MUL_ROUND  = 1'b0,
   parameter real SEED_BIAS  = 0.222222,
   parameter real SEED_SLOPE = 0.888889
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] x_in,
   output logic              ready,
   output logic              done,
   output logic [DATA_W-1:0] y_out
);

   localparam int CNT_W = $clog2(ITERS);

   generate
      if (ITERS < 2 || (1 << CNT_W) != ITERS) begin : g_bad_iters
         $error("ITERS must be a power of two of at least 2");
      end
      if (FRAC_W < 1 || FRAC_W >= DATA_W) begin : g_bad_frac
         $error("FRAC_W must lie between 1 and DATA_W-1");
      end
   endgenerate

   alu_op_e            alu_op;
   dp_ctl_t            dpc;
   logic               load_x, cnt_zero;
   logic [DATA_W-1:0]  opa, opb;
   logic [DATA_W:0]    alu_res;

   nsq_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cnt_zero (cnt_zero),
      .alu_op   (alu_op),
      .dpc      (dpc),
      .load_x   (load_x),
      .ready    (ready),
      .done     (done)
   );

   nsq_datapath #(
      .DATA_W     (DATA_W),
      .FRAC_W     (FRAC_W),
      .CNT_W      (CNT_W),
      .SEED_BIAS  (SEED_BIAS),
      .SEED_SLOPE (SEED_SLOPE)
   ) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_x   (load_x),
      .x_in     (x_in),
      .dpc      (dpc),
      .alu_res  (alu_res),
      .opa      (opa),
      .opb      (opb),
      .y        (y_out),
      .cnt_zero (cnt_zero)
   );

   nsq_alu #(
      .DATA_W    (DATA_W),
      .FRAC_W    (FRAC_W),
      .MUL_ROUND (MUL_ROUND)
   ) u_alu (
      .op  (alu_op),
      .a   (opa),
      .b   (opb),
      .res (alu_res)
   );

endmodule

// File: rtl/nsq_checker.sv
module nsq_checker #(
   parameter int DATA_W = 16,
   parameter int ITERS  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              ready,
   input logic              done,
   input logic [DATA_W-1:0] y_out
);

   localparam int STEPS = 3 + 5 * ITERS;
   localparam int CW    = $clog2(STEPS + 2);

   logic [CW-1:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since_q <= '0;
      else if (start && ready)   since_q <= CW'(1);
      else if (done)             since_q <= '0;
      else if (since_q != '0 && since_q != '1) since_q <= since_q + CW'(1);
   end

   AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> !ready); // R2

   AST_DONE_ON_LAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (since_q == CW'(STEPS))); // R3

   AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R3

   AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ready); // R8

   AST_IDLE_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !start) |=> $stable(y_out)); // R6

   AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ready); // R6

endmodule

bind nsq_top nsq_checker #(
   .DATA_W (DATA_W),
   .ITERS  (ITERS)
) u_nsq_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .ready (ready),
   .done  (done),
   .y_out (y_out)
);

// File: tb/tb_nsq_top.sv
module tb_nsq_top;

   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 23;
   localparam int TOL        = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] x_in = '0;
   logic        ready, done;
   logic [15:0] y_out;

   int n_chk  = 0;
   int n_fail = 0;

   nsq_top dut (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .x_in  (x_in),
      .ready (ready),
      .done  (done),
      .y_out (y_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int ref_sqrt(input int xv);
      return $rtoi($sqrt(real'(xv) / 32768.0) * 32768.0 + 0.5);
   endfunction

   function automatic int absdiff(input int a, input int b);
      return (a > b) ? a - b : b - a;
   endfunction

   // Called at the first falling edge after the accepting edge; counts to done.
   task automatic count_to_done(input int intr_at, input int intr_x, output int cyc);
      cyc = 1;
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
         if (intr_at != 0 && cyc == intr_at) begin
            start = 1'b1;
            x_in  = 16'(intr_x);
         end else begin
            start = 1'b0;
         end
      end
   endtask

   task automatic run_op(input int xv, input int intr_at, input int intr_x,
                         output int yv, output int cyc);
      @(negedge clk);
      x_in  = 16'(xv);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(ready == 1'b0, "R2 ready low after accept", int'(ready), 0);
      count_to_done(intr_at, intr_x, cyc);
      yv = int'(y_out);
   endtask

   task automatic t_reset();
      check(ready == 1'b1, "R1 ready in reset", int'(ready), 1);
      check(done == 1'b0, "R1 done in reset", int'(done), 0);
      check(y_out == 16'd0, "R1 y in reset", int'(y_out), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(ready == 1'b1 && done == 1'b0, "R1 idle after reset", int'({ready, done}), 2);
      check(y_out == 16'd0, "R1 y after reset", int'(y_out), 0);
   endtask

   task automatic t_single(input int xv, input string tag);
      int yv, cyc, e;
      e = ref_sqrt(xv);
      run_op(xv, 0, 0, yv, cyc);
      check(cyc == LAT, {tag, " R3 latency"}, cyc, LAT);
      check(absdiff(yv, e) <= TOL, {tag, " R4 result"}, yv, e);
      @(negedge clk);
      check(done == 1'b0, {tag, " R3 single pulse"}, int'(done), 0);
      check(ready == 1'b1, {tag, " R6 ready after done"}, int'(ready), 1);
      check(int'(y_out) == yv, {tag, " R6 result held"}, int'(y_out), yv);
   endtask

   task automatic t_hold();
      int yv, cyc;
      run_op(16'h4000, 0, 0, yv, cyc);
      repeat (7) @(negedge clk);
      check(int'(y_out) == yv, "R6 result held idle", int'(y_out), yv);
      check(ready == 1'b1 && done == 1'b0, "R6 idle state", int'({ready, done}), 2);
   endtask

   task automatic t_busy_ignore();
      int yv, cyc, e;
      e = ref_sqrt(16'h2000);
      run_op(16'h2000, 5, 16'h6000, yv, cyc);
      check(cyc == LAT, "R5 latency with busy start", cyc, LAT);
      check(absdiff(yv, e) <= TOL, "R5 first operand kept", yv, e);
      e = ref_sqrt(16'h2000);
      run_op(16'h2000, 20, 16'h7F00, yv, cyc);
      check(cyc == LAT, "R5 late busy start latency", cyc, LAT);
      check(absdiff(yv, e) <= TOL, "R5 late busy start result", yv, e);
   endtask

   task automatic t_back2back();
      int ya, yb, cyc, ea, eb;
      ea = ref_sqrt(16'h1234);
      eb = ref_sqrt(16'h5A5A);
      run_op(16'h1234, 0, 0, ya, cyc);
      check(absdiff(ya, ea) <= TOL, "R8 first result", ya, ea);
      start = 1'b1;
      x_in  = 16'h5A5A;
      @(negedge clk);
      check(ready == 1'b1, "R8 start in done cycle ignored", int'(ready), 1);
      check(int'(y_out) == ya, "R8 result unchanged", int'(y_out), ya);
      @(negedge clk);
      start = 1'b0;
      check(ready == 1'b0, "R8 accepted one cycle later", int'(ready), 0);
      count_to_done(0, 0, cyc);
      yb = int'(y_out);
      check(cyc == LAT, "R8 second latency", cyc, LAT);
      check(absdiff(yb, eb) <= TOL, "R8 second result", yb, eb);
   endtask

   task automatic t_ends();
      int yv, cyc;
      run_op(2048, 0, 0, yv, cyc);
      check(absdiff(yv, 8192) <= TOL, "R7 low end", yv, 8192);
      check(cyc == LAT, "R7 low end latency", cyc, LAT);
      run_op(32767, 0, 0, yv, cyc);
      check(absdiff(yv, 32767) <= TOL, "R7 high end", yv, 32767);
      check(cyc == LAT, "R7 high end latency", cyc, LAT);
   endtask

   task automatic t_sweep();
      for (int k = 0; k < 40; k++) begin
         int xv, yv, cyc, e;
         xv = 2048 + k * 784;
         e  = ref_sqrt(xv);
         run_op(xv, 0, 0, yv, cyc);
         check(absdiff(yv, e) <= TOL, "R4 sweep result", yv, e);
         check(cyc == LAT, "R3 sweep latency", cyc, LAT);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_single(16'h2000, "quarter");
      t_single(16'h4000, "half");
      t_single(16'h0C00, "small");
      t_single(16'h7000, "large");
      t_hold();
      t_busy_ignore();
      t_back2back();
      t_ends();
      t_sweep();
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule